// File: doc/BRIEF.md
# Register-Controlled SPI Master

This block is a serial peripheral interface master that software runs through a small word-addressed register file. A write to the data register queues one character, together with the number of the chip select to drive and a flag that keeps that chip select asserted afterwards. The engine then asserts the active-low chip select and waits a programmable setup time. It shifts the character out on MOSI while it generates SCLK and samples MISO. It then either keeps the chip select asserted for the next word of the same frame, or waits a programmable hold time and releases it.

Character length, clock prescaler, clock phase, clock polarity and bit order are taken from a format register. Software polls a status register for a received character. A one-deep transmit holding buffer lets the next word be queued while the current one shifts, so a multi-character frame runs with no idle clock between characters. Lines that no transfer selects are driven to levels taken from a chip-select default register.

Register word index (on `reg_addr`): 0 = run control, 1 = mode control, 2 = format, 3 = delays, 4 = chip-select defaults, 5 = transmit data (write), 6 = receive/status (read).

Top module: `spim_ctrl`

## Requirements
- R1: After `rst_n` is released, every `cs_n` line is high and `sclk` is low. The status word then reads bit 31 (receive empty) as 1 and bit 29 (transmit full) as 0.
- R2: While bit 0 of the run register (index 0) is 0, the block is held in soft reset. Data writes are dropped, the buffer and receive flags stay clear, and no chip select is asserted.
- R3: A queued word waits, with transmit full set and no chip select asserted, until the mode register (index 1) has bits 0, 1 and 24 all set.
- R4: The format register (index 2) holds the character length in bits 4:0, clamped to 2..CHAR_W. Bit 20 selects the bit order: 0 sends the MSB first, 1 sends the LSB first. Bits of the same index are received in the same order.
- R5: One SCLK period lasts P = max(prescaler+1, 2) module clocks, where the prescaler is format bits 15:8. The first half of each bit cell lasts floor(P/2) clocks and the second half lasts the rest.
- R6: SCLK idles at the polarity bit (format bit 17). With the phase bit (format bit 16) set, data is valid before the first clock edge of each bit (mode 0 when polarity is 0). With the phase bit clear, data changes on the first edge of each bit and is sampled on the second.
- R7: The delay register (index 3) holds the setup time C in bits 31:24 and the hold time T in bits 23:16. From chip-select assertion to the first SCLK edge takes C+1 clocks, plus floor(P/2) when phase is set. From the last SCLK edge to release takes T+1 clocks, plus the second-half length when phase is clear.
- R8: In the data word, bits CHAR_W-1:0 carry the character, bits 16 and up select the chip select, and bit 28 is the hold flag. Only the selected `cs_n` line is driven low.
- R9: When a character ends with the hold flag set, its chip select stays low. If the next word is already buffered, it starts with no idle SCLK between the two characters.
- R10: Each `cs_n` line that no transfer selects is driven to its bit of the chip-select default register (index 4).
- R11: The status word (index 6) reports receive empty in bit 31, overrun in bit 30, transmit full in bit 29 and the received character in its low bits. Reading it sets receive empty and clears overrun.
- R12: A character that completes while the previous one is still unread overwrites it and sets the overrun bit.
- R13: A data write while transmit full is set is dropped, and the buffered word is kept and sent unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects on status) |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | NCS | Active-low chip selects |

## Verification
A wrong count in the bit-cell or delay counters shows up within one character as a shifted distance, in clocks, between the chip-select edges and the first and last SCLK edge. A wrong bit index shows up at the end of the same character as a permuted word at the slave or in the status register. Errors in buffer or receive flag state become visible at the next status read: a lost or repeated character, a missing or spurious overrun bit, or a transmit-full bit that does not match the writes. A chip-select state error shows up on the `cs_n` lines as soon as a frame should end or continue.

// File: rtl/spim_pkg.sv
package spim_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_SHIFT, ST_HOLD} spim_state_e;

  typedef struct packed {
    logic       lsb_first;
    logic       pol;
    logic       pha;
    logic [7:0] pre;
    logic [4:0] len;
  } spim_fmt_t;

  localparam int unsigned HOLD_BIT = 28;
  localparam int unsigned CSN_LSB  = 16;
  localparam int unsigned RXE_BIT  = 31;
  localparam int unsigned OVR_BIT  = 30;
  localparam int unsigned TXF_BIT  = 29;

  // total clocks per bit cell, never below two
  function automatic logic [8:0] cell_clocks(input logic [7:0] pre);
    logic [8:0] p;
    p = {1'b0, pre} + 9'd1;
    return (p < 9'd2) ? 9'd2 : p;
  endfunction

  function automatic logic [7:0] first_half(input logic [7:0] pre);
    logic [8:0] p;
    p = cell_clocks(pre) >> 1;
    return p[7:0];
  endfunction

  function automatic logic [7:0] second_half(input logic [7:0] pre);
    logic [8:0] p;
    p = cell_clocks(pre) - (cell_clocks(pre) >> 1);
    return p[7:0];
  endfunction

  function automatic logic [4:0] clamp_len(input logic [4:0] len, input int unsigned maxw);
    if (len < 5'd2) return 5'd2;
    if (32'(len) > maxw) return 5'(maxw);
    return len;
  endfunction

endpackage

// File: rtl/spim_regs.sv
module spim_regs
  import spim_pkg::*;
#(
  parameter int unsigned CHAR_W = 16,
  parameter int unsigned NCS    = 4,
  parameter int unsigned CSW    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              srst,
  output logic              go,
  output spim_fmt_t         fmt,
  output logic [7:0]        c2t,
  output logic [7:0]        t2c,
  output logic [NCS-1:0]    csdef,
  output logic              tx_valid,
  output logic [CHAR_W-1:0] tx_char,
  output logic [CSW-1:0]    tx_cs,
  output logic              tx_hold,
  input  logic              tx_take,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_char
);

  logic run, m_bit, ic_bit, en_bit;
  logic rx_full, ovr;
  logic [CHAR_W-1:0] rx_q;

  logic data_wr, stat_rd;
  assign data_wr = reg_wr && (reg_addr == 3'd5);
  assign stat_rd = reg_rd && (reg_addr == 3'd6);
  assign srst    = !run;
  assign go      = run && m_bit && ic_bit && en_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; m_bit <= 1'b0; ic_bit <= 1'b0; en_bit <= 1'b0;
      fmt <= '{lsb_first: 1'b0, pol: 1'b0, pha: 1'b0, pre: 8'd0, len: 5'd8};
      c2t <= '0; t2c <= '0; csdef <= '1;
      tx_valid <= 1'b0; tx_char <= '0; tx_cs <= '0; tx_hold <= 1'b0;
      rx_full <= 1'b0; ovr <= 1'b0; rx_q <= '0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          3'd0: run <= reg_wdata[0];
          3'd1: begin m_bit <= reg_wdata[0]; ic_bit <= reg_wdata[1]; en_bit <= reg_wdata[24]; end
          3'd2: fmt <= '{lsb_first: reg_wdata[20], pol: reg_wdata[17], pha: reg_wdata[16],
                         pre: reg_wdata[15:8], len: reg_wdata[4:0]};
          3'd3: begin c2t <= reg_wdata[31:24]; t2c <= reg_wdata[23:16]; end
          3'd4: csdef <= reg_wdata[NCS-1:0];
          default: ;
        endcase
      end
      if (!run) begin
        tx_valid <= 1'b0; rx_full <= 1'b0; ovr <= 1'b0;
      end else begin
        if (tx_take) tx_valid <= 1'b0;
        if (data_wr && !tx_valid) begin
          tx_valid <= 1'b1;
          tx_char  <= reg_wdata[CHAR_W-1:0];
          tx_cs    <= reg_wdata[CSN_LSB +: CSW];
          tx_hold  <= reg_wdata[HOLD_BIT];
        end
        if (rx_valid) begin
          rx_q    <= rx_char;
          rx_full <= 1'b1;
          if (rx_full && !stat_rd) ovr <= 1'b1;
          else if (stat_rd)        ovr <= 1'b0;
        end else if (stat_rd) begin
          rx_full <= 1'b0;
          ovr     <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      3'd0: reg_rdata[0] = run;
      3'd1: begin reg_rdata[0] = m_bit; reg_rdata[1] = ic_bit; reg_rdata[24] = en_bit; end
      3'd2: begin
        reg_rdata[4:0]  = fmt.len;   reg_rdata[15:8] = fmt.pre;
        reg_rdata[16]   = fmt.pha;   reg_rdata[17]   = fmt.pol;
        reg_rdata[20]   = fmt.lsb_first;
      end
      3'd3: begin reg_rdata[31:24] = c2t; reg_rdata[23:16] = t2c; end
      3'd4: reg_rdata[NCS-1:0] = csdef;
      3'd6: begin
        reg_rdata[RXE_BIT] = !rx_full;
        reg_rdata[OVR_BIT] = ovr;
        reg_rdata[TXF_BIT] = tx_valid;
        reg_rdata[CHAR_W-1:0] = rx_q;
      end
      default: ;
    endcase
  end

  // R13
  tx_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n || srst)
    (data_wr && tx_valid && !tx_take) |=> (tx_valid && $stable(tx_char) && $stable(tx_cs) && $stable(tx_hold)));
  // R12
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n || srst)
    (rx_valid && rx_full && !stat_rd) |=> ovr);
  // R11
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n || srst)
    (stat_rd && !rx_valid) |=> (!rx_full && !ovr));

endmodule

// File: rtl/spim_engine.sv
module spim_engine
  import spim_pkg::*;
#(
  parameter int unsigned CHAR_W = 16,
  parameter int unsigned NCS    = 4,
  parameter int unsigned CSW    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              srst,
  input  logic              go,
  input  spim_fmt_t         fmt,
  input  logic [7:0]        c2t,
  input  logic [7:0]        t2c,
  input  logic              tx_valid,
  input  logic [CHAR_W-1:0] tx_char,
  input  logic [CSW-1:0]    tx_cs,
  input  logic              tx_hold,
  output logic              tx_take,
  output logic              rx_valid,
  output logic [CHAR_W-1:0] rx_char,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic [NCS-1:0]    cs_act
);

  localparam int unsigned IW = (CHAR_W > 1) ? $clog2(CHAR_W) : 1;

  spim_state_e       state;
  logic [7:0]        cnt;
  logic              half, held, cur_hold;
  logic [4:0]        bitcnt;
  logic [CHAR_W-1:0] txw, rxsh;
  logic [CSW-1:0]    cur_cs;

  logic [4:0] len, idx;
  logic [7:0] h1, h2;
  logic cell_end, last_bit, char_done, chain, start, cs_on;

  assign len       = clamp_len(fmt.len, CHAR_W);
  assign h1        = first_half(fmt.pre);
  assign h2        = second_half(fmt.pre);
  assign idx       = fmt.lsb_first ? bitcnt : (len - 5'd1 - bitcnt);
  assign cell_end  = (state == ST_SHIFT) && half && (cnt == h2 - 8'd1);
  assign last_bit  = (bitcnt == len - 5'd1);
  assign char_done = cell_end && last_bit;
  assign chain     = char_done && cur_hold && tx_valid && go;
  assign start     = (state == ST_IDLE) && go && tx_valid;
  assign tx_take   = start || chain;
  assign rx_valid  = char_done;
  assign rx_char   = rxsh;
  assign cs_on     = (state != ST_IDLE) || held;
  assign sclk      = fmt.pol ^ ((state == ST_SHIFT) && (half ^ !fmt.pha));
  assign mosi      = (state == ST_SHIFT) ? txw[idx[IW-1:0]] : 1'b0;

  for (genvar i = 0; i < NCS; i++) begin : g_cs
    assign cs_act[i] = cs_on && (cur_cs == CSW'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; cnt <= '0; half <= 1'b0; held <= 1'b0; cur_hold <= 1'b0;
      bitcnt <= '0; txw <= '0; rxsh <= '0; cur_cs <= '0;
    end else if (srst) begin
      state <= ST_IDLE; cnt <= '0; half <= 1'b0; held <= 1'b0; cur_hold <= 1'b0;
      bitcnt <= '0; txw <= '0; rxsh <= '0; cur_cs <= '0;
    end else begin
      if (tx_take) begin
        txw <= tx_char; cur_cs <= tx_cs; cur_hold <= tx_hold;
        bitcnt <= '0; half <= 1'b0; rxsh <= '0; held <= 1'b0;
      end
      case (state)
        ST_IDLE: if (start) begin
          if (held) begin state <= ST_SHIFT; cnt <= '0; end
          else      begin state <= ST_SETUP; cnt <= c2t; end
        end
        ST_SETUP: if (cnt == 8'd0) state <= ST_SHIFT;
                  else             cnt <= cnt - 8'd1;
        ST_SHIFT: if (!half) begin
          if (cnt == h1 - 8'd1) begin
            half <= 1'b1; cnt <= '0; rxsh[idx[IW-1:0]] <= miso;
          end else cnt <= cnt + 8'd1;
        end else if (cell_end) begin
          cnt <= '0;
          if (!last_bit) begin
            bitcnt <= bitcnt + 5'd1; half <= 1'b0;
          end else if (!chain) begin
            if (cur_hold) begin state <= ST_IDLE; held <= 1'b1; end
            else          begin state <= ST_HOLD; cnt <= t2c; end
          end
        end else cnt <= cnt + 8'd1;
        ST_HOLD: if (cnt == 8'd0) state <= ST_IDLE;
                 else             cnt <= cnt - 8'd1;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5
  cell_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n || srst)
    (state == ST_SHIFT) |-> (cnt < (half ? h2 : h1)));
  // R8
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n || srst)
    $onehot0(cs_act));
  // R6
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n || srst)
    (cs_act == '0) |-> (sclk == fmt.pol));
  // R9
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || srst)
    (char_done && cur_hold) |=> (cs_act != '0));

endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int unsigned CHAR_W = 16,
  parameter int unsigned NCS    = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic           reg_rd,
  input  logic [2:0]     reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  output logic           sclk,
  output logic           mosi,
  input  logic           miso,
  output logic [NCS-1:0] cs_n
);

  localparam int unsigned CSW = (NCS > 1) ? $clog2(NCS) : 1;

  spim_fmt_t         fmt;
  logic              srst, go, tx_valid, tx_hold, tx_take, rx_valid;
  logic [7:0]        c2t, t2c;
  logic [NCS-1:0]    csdef, cs_act;
  logic [CHAR_W-1:0] tx_char, rx_char;
  logic [CSW-1:0]    tx_cs;

  spim_regs #(.CHAR_W(CHAR_W), .NCS(NCS), .CSW(CSW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .srst(srst), .go(go), .fmt(fmt),
    .c2t(c2t), .t2c(t2c), .csdef(csdef), .tx_valid(tx_valid), .tx_char(tx_char),
    .tx_cs(tx_cs), .tx_hold(tx_hold), .tx_take(tx_take), .rx_valid(rx_valid), .rx_char(rx_char)
  );

  spim_engine #(.CHAR_W(CHAR_W), .NCS(NCS), .CSW(CSW)) u_engine (
    .clk(clk), .rst_n(rst_n), .srst(srst), .go(go), .fmt(fmt), .c2t(c2t), .t2c(t2c),
    .tx_valid(tx_valid), .tx_char(tx_char), .tx_cs(tx_cs), .tx_hold(tx_hold),
    .tx_take(tx_take), .rx_valid(rx_valid), .rx_char(rx_char), .miso(miso),
    .sclk(sclk), .mosi(mosi), .cs_act(cs_act)
  );

  for (genvar i = 0; i < NCS; i++) begin : g_csn
    assign cs_n[i] = cs_act[i] ? 1'b0 : csdef[i];
  end

  // R10
  cs_default_chk: assert property (@(posedge clk) disable iff (!rst_n || srst)
    (cs_act == '0) |-> (cs_n == csdef));

endmodule

// File: tb/spim_ctrl_tb.sv
module spim_ctrl_tb;

  localparam int CHAR_W = 16;
  localparam int NCS    = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic sclk, mosi, miso = 1'b0;
  logic [NCS-1:0] cs_n;

  spim_ctrl #(.CHAR_W(CHAR_W), .NCS(NCS)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk(sclk), .mosi(mosi),
    .miso(miso), .cs_n(cs_n)
  );

  always #2.5 clk = ~clk;

  int checks = 0, failures = 0;

  // ---------------- bench model of the rules ----------------
  function automatic int f_len(input int field);
    if (field < 2) return 2;
    if (field > CHAR_W) return CHAR_W;
    return field;
  endfunction
  function automatic int f_lead(input int pre);
    int p = (pre + 1 < 2) ? 2 : pre + 1;
    return p / 2;
  endfunction
  function automatic int f_trail(input int pre);
    int p = (pre + 1 < 2) ? 2 : pre + 1;
    return (p + 1) / 2;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- slave model ----------------
  int s_sel = 0, s_len = 8;
  bit s_pol = 0, s_pha = 1, s_lsb = 0;
  logic [15:0] s_tx[4], s_rx[4];
  logic [NCS-1:0] exp_def = '1;
  int cyc = 0, t_csf = 0, t_first = 0, t_last = 0, d_setup = -1, d_hold = -1, ki = 0, ko = 0;
  bit got_edge = 0, prev_cs = 0, wrong_cs = 0;
  logic prev_sclk = 1'b0;

  function automatic int pos(input int k);
    int j = k % s_len;
    return s_lsb ? j : s_len - 1 - j;
  endfunction

  always @(negedge clk) begin
    bit cs_low, lead;
    cyc++;
    cs_low = (cs_n[s_sel] == 1'b0) && (exp_def[s_sel] == 1'b1);
    for (int i = 0; i < NCS; i++)
      if (i != s_sel && cs_n[i] != exp_def[i]) wrong_cs = 1;
    if (cs_low && !prev_cs) begin
      t_csf = cyc; got_edge = 0; ki = 0; ko = 0;
      if (s_pha) begin miso = s_tx[0][pos(0)]; ko = 1; end
    end
    if (cs_low && sclk != prev_sclk) begin
      if (!got_edge) begin d_setup = cyc - t_csf; got_edge = 1; t_first = cyc; end
      t_last = cyc;
      lead = (sclk != s_pol);
      if (lead == s_pha) begin
        if (ki / s_len < 4) s_rx[ki / s_len][pos(ki)] = mosi;
        ki++;
      end else begin
        miso = (ko / s_len < 4) ? s_tx[ko / s_len][pos(ko)] : 1'b0;
        ko++;
      end
    end
    if (!cs_low && prev_cs) d_hold = cyc - t_last;
    prev_cs = cs_low;
    prev_sclk = sclk;
  end

  // ---------------- register access ----------------
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a; #1; d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic poll_rx(output logic [31:0] st);
    st = 32'h8000_0000;
    for (int n = 0; n < 3000 && st[31]; n++) rd(3'd6, st);
  endtask

  task automatic wait_release();
    for (int n = 0; n < 3000 && cs_n != exp_def; n++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [31:0] fmt_word(int lenf, int pre, bit pha, bit pol, bit lsb);
    return (32'(lsb) << 20) | (32'(pol) << 17) | (32'(pha) << 16) | (32'(pre) << 8) | 32'(lenf);
  endfunction
  function automatic logic [31:0] dat_word(int cs, bit hold, logic [15:0] ch);
    return (32'(hold) << 28) | (32'(cs) << 16) | 32'(ch);
  endfunction

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  // ---------------- main ----------------
  initial begin
    logic [31:0] st;
    logic [15:0] ch, mask;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4; i++) begin s_tx[i] = '0; s_rx[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(cs_n == 4'hF && sclk == 1'b0, "R1 pins", {cs_n, 3'b0, sclk}, 32'hF0);
    rd(3'd6, st);
    chk(st[31] == 1'b1 && st[29] == 1'b0, "R1 status", st, 32'h8000_0000);

    // R2 soft reset drops data writes
    wr(3'd1, 32'h0100_0003);
    wr(3'd5, dat_word(0, 0, 16'h5A));
    repeat (20) @(negedge clk);
    chk(cs_n == 4'hF, "R2 no cs", cs_n, 4'hF);
    rd(3'd6, st);
    chk(st[29] == 1'b0 && st[31] == 1'b1, "R2 status", st, 32'h8000_0000);

    // R3 engine waits for all mode bits
    wr(3'd1, 32'h0000_0003);
    wr(3'd0, 32'h1);
    wr(3'd2, fmt_word(8, 1, 1, 0, 0));
    wr(3'd3, 32'h0101_0000);
    s_sel = 0; s_len = 8; s_pha = 1; s_pol = 0; s_lsb = 0; s_tx[0] = 16'h3C;
    wr(3'd5, dat_word(0, 0, 16'hA5));
    repeat (20) @(negedge clk);
    chk(cs_n == 4'hF, "R3 idle while disabled", cs_n, 4'hF);
    rd(3'd6, st);
    chk(st[29] == 1'b1, "R3 word queued", st[29], 1);
    wr(3'd1, 32'h0100_0003);
    poll_rx(st);
    chk(st[7:0] == 8'h3C, "R3 rx", st[7:0], 8'h3C);
    wait_release();
    chk(s_rx[0][7:0] == 8'hA5, "R3 tx", s_rx[0][7:0], 8'hA5);

    // R10 idle levels from default register
    exp_def = 4'b0101; wr(3'd4, 32'h5);
    repeat (2) @(negedge clk);
    chk(cs_n == 4'b0101, "R10 defaults", cs_n, 4'b0101);
    exp_def = 4'hF; wr(3'd4, 32'hF);
    repeat (2) @(negedge clk);
    chk(cs_n == 4'hF, "R10 restore", cs_n, 4'hF);

    // random transfers: R4 R5 R6 R7 R8 R11
    wrong_cs = 0;
    for (int it = 0; it < 24; it++) begin
      int lf, pre, c2, t2, cs, ln, es, eh;
      bit pha, pol, lsb;
      lf = $urandom_range(0, 20); pre = $urandom_range(0, 4);
      pha = 1'($urandom_range(0, 1)); pol = 1'($urandom_range(0, 1)); lsb = 1'($urandom_range(0, 1));
      c2 = $urandom_range(0, 5); t2 = $urandom_range(0, 5); cs = $urandom_range(0, NCS - 1);
      ln = f_len(lf);
      mask = (ln >= 16) ? 16'hFFFF : 16'((1 << ln) - 1);
      ch = 16'($urandom);
      s_sel = cs; s_len = ln; s_pha = pha; s_pol = pol; s_lsb = lsb;
      s_tx[0] = 16'($urandom) & mask; s_rx[0] = '0;
      wr(3'd2, fmt_word(lf, pre, pha, pol, lsb));
      wr(3'd3, (32'(c2) << 24) | (32'(t2) << 16));
      wr(3'd5, dat_word(cs, 0, ch));
      poll_rx(st);
      chk(st[15:0] == s_tx[0] && st[30] == 1'b0, "R11 rx char", st, {16'h0, s_tx[0]});
      wait_release();
      chk((s_rx[0] & mask) == (ch & mask), "R4 slave got", s_rx[0] & mask, ch & mask);
      es = c2 + 1 + (pha ? f_lead(pre) : 0);
      eh = t2 + 1 + (pha ? 0 : f_trail(pre));
      chk(d_setup == es, "R7 R5 setup", d_setup, es);
      chk(d_hold == eh, "R7 R5 hold", d_hold, eh);
      chk(sclk == pol, "R6 idle level", sclk, pol);
      chk(!wrong_cs, "R8 only selected cs", wrong_cs, 0);
    end

    // frame: R9 R12 R13
    s_sel = 1; s_len = 8; s_pha = 1; s_pol = 0; s_lsb = 0;
    s_tx[0] = 16'h11; s_tx[1] = 16'h22; s_tx[2] = 16'h33;
    for (int i = 0; i < 4; i++) s_rx[i] = '0;
    wr(3'd2, fmt_word(8, 1, 1, 0, 0));
    wr(3'd3, 32'h0202_0000);
    wr(3'd5, dat_word(1, 1, 16'hC1));
    wr(3'd5, dat_word(1, 1, 16'hC2));
    rd(3'd6, st);
    chk(st[29] == 1'b1, "R13 full flag", st[29], 1);
    wr(3'd5, dat_word(1, 0, 16'hEE));
    repeat (100) @(negedge clk);
    chk(cs_n[1] == 1'b0, "R9 cs held", cs_n[1], 0);
    chk(t_last - t_first == 31, "R9 no gap", t_last - t_first, 31);
    chk(ki == 16, "R13 dropped write", ki, 16);
    rd(3'd6, st);
    chk(st[30] == 1'b1 && st[7:0] == 8'h22 && st[29] == 1'b0, "R12 overrun", st, 32'h4000_0022);
    chk(s_rx[0] == 16'hC1 && s_rx[1] == 16'hC2, "R13 buffer kept", {s_rx[0], s_rx[1]}, 32'h00C1_00C2);
    wr(3'd5, dat_word(1, 0, 16'hD4));
    poll_rx(st);
    chk(st[30] == 1'b0 && st[7:0] == 8'h33, "R11 clear on read", st, 32'h33);
    wait_release();
    chk(cs_n == 4'hF && s_rx[2] == 16'hD4, "R9 frame end", {cs_n, s_rx[2]}, {4'hF, 16'hD4});

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule